// File: doc/BRIEF.md
# Signed Multi-Operand Adder with Sign-Bit Correction

This block adds `N_OPS` two's-complement operands of `WIDTH` bits each and returns their exact sum on a result `WIDTH + clog2(N_OPS)` bits wide. It is purely combinational, so the result follows the operands within the same cycle. All operands arrive packed side by side on one input bus.

The block does not copy each sign bit into every upper column. Each operand's top bit is inverted, and that bit is read as worth one negative unit of the sign column. All of those negative units are folded into one constant when the design is elaborated. The constant is found by walking the columns upward. Pairs of negative units merge into one unit in the next column. A single leftover becomes a set bit in its own column and carries one negative unit upward. A unit that leaves the top of the result is dropped.

The formed rows and the constant row pass through a chain of 3:2 carry-save compressors, and one carry-propagate adder then resolves them. A parameter selects the correction scheme or a plain full-width sign-extension variant. Both variants produce the same value.

Top module: `signed_csa_sum`

## Requirements
- R1: `sum_o` equals the two's-complement sum of all operands, taken modulo 2^(WIDTH+clog2(N_OPS)). Operand i occupies bits `[i*WIDTH +: WIDTH]` of `ops_i`. The result follows the inputs combinationally.
- R2: When every operand is zero, `sum_o` is zero.
- R3: When every operand is the most negative value (only the top bit set), `sum_o` equals -N_OPS * 2^(WIDTH-1). With the defaults this is 11'h580.
- R4: When every operand is the most positive value, `sum_o` equals N_OPS * (2^(WIDTH-1) - 1). With the defaults this is 11'h27B.
- R5: When no operand has its top bit set, the top bit of `sum_o` is 0.
- R6: The result does not depend on which lane holds which operand. Rotating the lanes leaves `sum_o` unchanged.
- R7: The correction variant (`USE_CORR=1`) and the full sign-extension variant (`USE_CORR=0`) give the same `sum_o` for the same operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops_i | input | N_OPS*WIDTH | Packed two's-complement operands, lane i at bits [i*WIDTH +: WIDTH] |
| sum_o | output | WIDTH+clog2(N_OPS) | Two's-complement sum of all lanes |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between `ops_i` and `sum_o`. The bench changes the operands on a rising clock edge and reads `sum_o` on the following falling edge, so the combinational path has settled before each comparison. Each check compares the output against a sign-extended sum that the bench computes itself. A second instance, built as the sign-extension variant, is read at the same falling edge for the cross-check.

// File: rtl/scs_pkg.sv
package scs_pkg;

    // Fold n negative units at column (w-1) upward through columns < rw.
    // An odd count leaves +1 in the column and sends one unit up; pairs merge.
    function automatic logic [63:0] corr_word(input int n, input int w, input int rw);
        logic [63:0]  acc;
        int unsigned  m;
        acc = '0;
        m   = n;
        for (int c = w - 1; c < rw; c++) begin
            acc[c] = m[0];
            m      = (m + 1) >> 1;
        end
        return acc;
    endfunction

endpackage

// File: rtl/scs_row_form.sv
module scs_row_form #(
    parameter int WIDTH    = 8,
    parameter int RW       = 11,
    parameter bit USE_CORR = 1'b1
) (
    input  logic [WIDTH-1:0] op_i,
    output logic [RW-1:0]    row_o
);
    localparam int PAD = RW - WIDTH;

    generate
        if (USE_CORR) begin : g_flip
            // inverted sign bit, upper columns left empty
            assign row_o = {{PAD{1'b0}}, ~op_i[WIDTH-1], op_i[WIDTH-2:0]};
        end else begin : g_ext
            // replicated sign extension across the whole result width
            assign row_o = {{PAD{op_i[WIDTH-1]}}, op_i};
        end
    endgenerate
endmodule

// File: rtl/scs_csa.sv
module scs_csa #(
    parameter int RW = 11
) (
    input  logic [RW-1:0] a_i,
    input  logic [RW-1:0] b_i,
    input  logic [RW-1:0] c_i,
    output logic [RW-1:0] s_o,
    output logic [RW-1:0] cy_o
);
    logic [RW-1:0] maj;

    always_comb begin
        s_o  = a_i ^ b_i ^ c_i;
        maj  = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
        cy_o = {maj[RW-2:0], 1'b0};
    end
endmodule

// File: rtl/scs_chain.sv
module scs_chain #(
    parameter int N_ROWS = 6,
    parameter int RW     = 11
) (
    input  logic [N_ROWS-1:0][RW-1:0] rows_i,
    output logic [RW-1:0]             s_o,
    output logic [RW-1:0]             c_o
);
    localparam int STAGES = N_ROWS - 2;

    logic [STAGES:0][RW-1:0] st_s;
    logic [STAGES:0][RW-1:0] st_c;

    assign st_s[0] = rows_i[0];
    assign st_c[0] = rows_i[1];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            scs_csa #(.RW(RW)) u_csa (
                .a_i (st_s[g]),
                .b_i (st_c[g]),
                .c_i (rows_i[g+2]),
                .s_o (st_s[g+1]),
                .cy_o(st_c[g+1])
            );
        end
    endgenerate

    assign s_o = st_s[STAGES];
    assign c_o = st_c[STAGES];
endmodule

// File: rtl/signed_csa_sum.sv
module signed_csa_sum #(
    parameter int N_OPS    = 5,
    parameter int WIDTH    = 8,
    parameter bit USE_CORR = 1'b1,
    localparam int RW      = WIDTH + $clog2(N_OPS)
) (
    input  logic [N_OPS*WIDTH-1:0] ops_i,
    output logic [RW-1:0]          sum_o
);
    import scs_pkg::*;

    localparam int          N_ROWS    = N_OPS + 1;
    localparam logic [63:0] CORR_FULL = corr_word(N_OPS, WIDTH, RW);
    localparam logic [RW-1:0] CORR_ROW = USE_CORR ? CORR_FULL[RW-1:0] : '0;

    logic [N_ROWS-1:0][RW-1:0] rows;
    logic [RW-1:0]             tree_s;
    logic [RW-1:0]             tree_c;

    generate
        for (genvar i = 0; i < N_OPS; i++) begin : g_op
            scs_row_form #(
                .WIDTH   (WIDTH),
                .RW      (RW),
                .USE_CORR(USE_CORR)
            ) u_form (
                .op_i (ops_i[i*WIDTH +: WIDTH]),
                .row_o(rows[i])
            );
        end
    endgenerate

    assign rows[N_OPS] = CORR_ROW;

    scs_chain #(.N_ROWS(N_ROWS), .RW(RW)) u_chain (
        .rows_i(rows),
        .s_o   (tree_s),
        .c_o   (tree_c)
    );

    // final carry-propagate stage
    assign sum_o = tree_s + tree_c;
endmodule

// File: rtl/signed_csa_sum_chk.sv
module signed_csa_sum_chk #(
    parameter int N_OPS = 5,
    parameter int WIDTH = 8,
    parameter int RW    = 11
) (
    input logic [N_OPS*WIDTH-1:0] ops_i,
    input logic [RW-1:0]          sum_o
);
    logic [RW-1:0] ref_sum;
    logic          all_zero;
    logic          all_min;
    logic          all_max;
    logic          none_neg;

    always_comb begin
        ref_sum  = '0;
        all_zero = 1'b1;
        all_min  = 1'b1;
        all_max  = 1'b1;
        none_neg = 1'b1;
        for (int i = 0; i < N_OPS; i++) begin
            ref_sum = ref_sum + {{(RW-WIDTH){ops_i[i*WIDTH+WIDTH-1]}}, ops_i[i*WIDTH +: WIDTH]};
            if (ops_i[i*WIDTH +: WIDTH] != '0) all_zero = 1'b0;
            if (ops_i[i*WIDTH +: WIDTH] != {1'b1, {(WIDTH-1){1'b0}}}) all_min = 1'b0;
            if (ops_i[i*WIDTH +: WIDTH] != {1'b0, {(WIDTH-1){1'b1}}}) all_max = 1'b0;
            if (ops_i[i*WIDTH+WIDTH-1]) none_neg = 1'b0;
        end
    end

    always_comb begin
        if (!$isunknown(ops_i)) begin
            // R1
            sum_match_chk: assert (sum_o == ref_sum)
                else $error("sum mismatch %h vs %h", sum_o, ref_sum);
            // R2
            zero_in_chk: assert (!all_zero || sum_o == '0)
                else $error("zero operands gave %h", sum_o);
            // R3
            min_neg_chk: assert (!all_min || sum_o == RW'(-(N_OPS * (2 ** (WIDTH-1)))))
                else $error("most negative operands gave %h", sum_o);
            // R4
            max_pos_chk: assert (!all_max || sum_o == RW'(N_OPS * (2 ** (WIDTH-1) - 1)))
                else $error("most positive operands gave %h", sum_o);
            // R5
            non_neg_chk: assert (!none_neg || !sum_o[RW-1])
                else $error("non-negative operands gave negative %h", sum_o);
        end
    end
endmodule

bind signed_csa_sum signed_csa_sum_chk #(
    .N_OPS(N_OPS),
    .WIDTH(WIDTH),
    .RW   (RW)
) u_chk (
    .ops_i(ops_i),
    .sum_o(sum_o)
);

// File: tb/sim_signed_csa_sum.sv
module sim_signed_csa_sum;
    localparam int CLK_P  = 10;
    localparam int N_OPS  = 5;
    localparam int WIDTH  = 8;
    localparam int RW     = WIDTH + $clog2(N_OPS);
    localparam int BUSW   = N_OPS * WIDTH;
    localparam int N_VEC  = 8;

    localparam logic [BUSW-1:0] VEC [N_VEC] = '{
        40'h01_02_03_04_05,
        40'hFF_FF_FF_FF_FF,
        40'h80_7F_80_7F_80,
        40'h7F_80_00_01_FF,
        40'h10_F0_20_E0_00,
        40'h55_AA_33_CC_0F,
        40'h80_00_00_00_00,
        40'hC0_C0_40_40_81
    };

    logic            clk;
    logic            rst;
    logic [BUSW-1:0] ops;
    logic [RW-1:0]   sum0;
    logic [RW-1:0]   sum1;
    int              checks;
    int              fails;
    bit              done;

    signed_csa_sum #(.N_OPS(N_OPS), .WIDTH(WIDTH), .USE_CORR(1'b1)) u0 (
        .ops_i(ops), .sum_o(sum0));
    signed_csa_sum #(.N_OPS(N_OPS), .WIDTH(WIDTH), .USE_CORR(1'b0)) u1 (
        .ops_i(ops), .sum_o(sum1));

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    function automatic logic [RW-1:0] model(input logic [BUSW-1:0] v);
        logic [RW-1:0] acc;
        acc = '0;
        for (int i = 0; i < N_OPS; i++)
            acc = acc + RW'($signed(v[i*WIDTH +: WIDTH]));
        return acc;
    endfunction

    task automatic check(input string req, input logic [RW-1:0] got, input logic [RW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [BUSW-1:0] v);
        @(posedge clk);
        ops = v;
        @(negedge clk);
    endtask

    initial begin
        checks = 0;
        fails  = 0;
        done   = 1'b0;
        rst    = 1'b1;
        ops    = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: zero operands after reset
        check("R2", sum0, '0);
        check("R7", sum1, '0);

        // R1 / R7: table walk
        for (int k = 0; k < N_VEC; k++) begin
            apply(VEC[k]);
            check("R1", sum0, model(VEC[k]));
            check("R7", sum1, sum0);
        end

        // R3: every lane most negative
        apply({N_OPS{8'h80}});
        check("R3", sum0, 11'h580);
        check("R7", sum1, 11'h580);

        // R4: every lane most positive
        apply({N_OPS{8'h7F}});
        check("R4", sum0, 11'h27B);

        // R5: non-negative operands give non-negative result
        apply(40'h7F_7F_7F_00_01);
        check("R5", {10'b0, sum0[RW-1]}, '0);
        check("R1", sum0, model(40'h7F_7F_7F_00_01));

        // R6: lane rotation leaves result unchanged; R1 on pseudo-random data
        begin
            logic [BUSW-1:0] lf;
            logic [RW-1:0]   base;
            lf = 40'hA5_3C_96_E1_7B;
            for (int k = 0; k < 40; k++) begin
                lf = {lf[BUSW-2:0], lf[BUSW-1] ^ lf[20] ^ lf[18] ^ lf[1]};
                apply(lf);
                check("R1", sum0, model(lf));
                check("R7", sum1, sum0);
                base = sum0;
                apply({lf[WIDTH-1:0], lf[BUSW-1:WIDTH]});
                check("R6", sum0, base);
            end
        end

        // R2 again after activity
        apply('0);
        check("R2", sum0, '0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule